// File: doc/BRIEF.md
# Collision Indication Gate with Heartbeat

This block drives the differential collision-indication pair that runs from a coax transceiver back to the host station. Three sources can ask for that indication: a collision level from an external comparator, a jabber status from the transmit watchdog, and a heartbeat that the block produces on its own. Whenever any source is active, the pair carries a square wave at one tenth of the system clock rate. This is a 10 MHz tone from a 100 MHz clock. When no source is active, both lines rest low, so the pair sits at zero differential.

The heartbeat is a self-test burst. Each end-of-transmit pulse starts a delay of `HB_DELAY` clock cycles. A request of `HB_LEN` cycles follows the delay. With the default values, this gives a burst of about 1 µs that begins about 1.1 µs after the transmission ends. A heartbeat-enable input turns the feature off for repeater use; collision and jabber indication still work when it is off. The gate opens and closes only on a boundary of the tone period, so the pair never carries a shortened half-cycle.

Top module: `coll_sig_ctrl`

## Requirements
- R1: While the gate is active, the positive line follows a square wave with a period of `DIV` clock cycles. It is high for the first `DIV/2` cycles of each period. Once active, the gate stays active for as long as any request is present.
- R2: Holding the collision input high activates the gate within `DIV`+1 cycles.
- R3: Holding the jabber input high activates the gate within `DIV`+1 cycles, with no collision or heartbeat present.
- R4: While the gate is inactive, both output lines are 0 and the active flag is 0.
- R5: An end-of-transmit pulse, sampled with heartbeat enable high, raises the heartbeat request `HB_DELAY`+1 cycles later, and the request lasts `HB_LEN` cycles. With no other request, the gate is observed active between `HB_DELAY`+2 and `HB_DELAY`+1+`DIV` cycles after the pulse. It stays active for a whole number of tone periods, at least `HB_LEN` and at most `HB_LEN`+`DIV` cycles.
- R6: With heartbeat enable low, end-of-transmit pulses produce no burst, and any pending or running heartbeat is cancelled. Collision and jabber still activate the gate.
- R7: An end-of-transmit pulse that arrives while a heartbeat is pending or running restarts the delay from that pulse.
- R8: While the gate is active, the negative line is the complement of the positive line.
- R9: The gate opens only at the start of a tone period, so the first active sample has the positive line high. It closes only at the end of a full period.
- R10: After synchronous reset, both lines and the active flag are 0, and no heartbeat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (DIV times the tone rate) |
| rst | input | 1 | Synchronous active-high reset |
| col_det_i | input | 1 | Collision level from the external comparator |
| jabber_i | input | 1 | Jabber status from the transmit watchdog |
| tx_end_i | input | 1 | One-cycle pulse marking the end of a transmission |
| hb_enable_i | input | 1 | High enables the heartbeat burst |
| ci_p_o | output | 1 | Gated positive collision line (registered) |
| ci_n_o | output | 1 | Gated negative collision line (registered) |
| ci_active_o | output | 1 | High while the gate is active |

## Verification
The assertions check the following on every cycle:
- both lines stay low while the gate is idle;
- the two lines are complementary while the gate is active;
- the gate opens only on the high half of a period and holds while a request is present;
- the phase counter wraps correctly;
- heartbeat enable cancels the timer;
- a sampled end-of-transmit pulse restarts the timer.

Only the bench scenarios can show the end-to-end heartbeat timing: the delay window and the burst length rounded up to whole periods. The same applies to restart timing, the absence of bursts when the heartbeat is disabled, and the duty cycle over full periods. The bench compares every output against a cycle model under random request traffic.

// File: rtl/coll_sig_pkg.sv
package coll_sig_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_t;
endpackage

// File: rtl/coll_phase_gen.sv
module coll_phase_gen #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  output logic ph_zero,
  output logic wave_hi
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_cnt;

  always_ff @(posedge clk) begin
    if (rst) ph_cnt <= '0;
    else if (ph_cnt == LAST) ph_cnt <= '0;
    else ph_cnt <= ph_cnt + 1'b1;
  end

  assign ph_zero = (ph_cnt == '0);
  assign wave_hi = (ph_cnt < PW'(HALF));

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (ph_cnt == LAST) |=> (ph_cnt == '0));
  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    (ph_cnt <= LAST));
endmodule

// File: rtl/coll_heartbeat.sv
module coll_heartbeat
  import coll_sig_pkg::*;
#(
  parameter int HB_DELAY = 110,
  parameter int HB_LEN   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_end,
  input  logic hb_en,
  output logic hb_req
);
  localparam int MAXC = (HB_DELAY > HB_LEN) ? HB_DELAY : HB_LEN;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] D_LAST = CW'(HB_DELAY - 1);
  localparam logic [CW-1:0] L_LAST = CW'(HB_LEN - 1);

  hb_state_t     state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !hb_en) begin
      state <= HB_IDLE;
      cnt   <= '0;
    end else if (tx_end) begin
      state <= HB_WAIT;
      cnt   <= '0;
    end else begin
      case (state)
        HB_WAIT: begin
          if (cnt == D_LAST) begin
            state <= HB_BURST;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        HB_BURST: begin
          if (cnt == L_LAST) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          state <= HB_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign hb_req = (state == HB_BURST);

  p_disable_r6: assert property (@(posedge clk) disable iff (rst)
    !hb_en |=> (state == HB_IDLE));
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (hb_en && tx_end) |=> (state == HB_WAIT && cnt == '0));
  p_burst_len_r5: assert property (@(posedge clk) disable iff (rst)
    (state == HB_BURST) |-> (cnt <= L_LAST));
endmodule

// File: rtl/coll_out_gate.sv
module coll_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic ph_zero,
  input  logic wave_hi,
  output logic cd_p,
  output logic cd_n,
  output logic gate_on
);
  logic on_nxt;

  always_comb begin
    on_nxt = ph_zero ? req : gate_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_on <= 1'b0;
      cd_p    <= 1'b0;
      cd_n    <= 1'b0;
    end else begin
      gate_on <= on_nxt;
      cd_p    <= on_nxt & wave_hi;
      cd_n    <= on_nxt & ~wave_hi;
    end
  end

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !gate_on |-> (!cd_p && !cd_n));
  p_complement_r8: assert property (@(posedge clk) disable iff (rst)
    gate_on |-> (cd_p != cd_n));
  p_start_high_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_on) |-> cd_p);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (gate_on && req) |=> gate_on);
endmodule

// File: rtl/coll_sig_ctrl.sv
module coll_sig_ctrl #(
  parameter int DIV      = 10,
  parameter int HB_DELAY = 110,
  parameter int HB_LEN   = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic col_det_i,
  input  logic jabber_i,
  input  logic tx_end_i,
  input  logic hb_enable_i,
  output logic ci_p_o,
  output logic ci_n_o,
  output logic ci_active_o
);
  logic ph_zero, wave_hi, hb_req, any_req;

  coll_phase_gen #(.DIV(DIV)) u_phase (
    .clk(clk), .rst(rst), .ph_zero(ph_zero), .wave_hi(wave_hi)
  );

  coll_heartbeat #(.HB_DELAY(HB_DELAY), .HB_LEN(HB_LEN)) u_hb (
    .clk(clk), .rst(rst), .tx_end(tx_end_i), .hb_en(hb_enable_i), .hb_req(hb_req)
  );

  assign any_req = col_det_i | jabber_i | hb_req;

  coll_out_gate u_gate (
    .clk(clk), .rst(rst), .req(any_req), .ph_zero(ph_zero), .wave_hi(wave_hi),
    .cd_p(ci_p_o), .cd_n(ci_n_o), .gate_on(ci_active_o)
  );

  p_col_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (ci_active_o && col_det_i) |=> ci_active_o);
  p_jab_holds_r3: assert property (@(posedge clk) disable iff (rst)
    (ci_active_o && jabber_i) |=> ci_active_o);
endmodule

// File: tb/tb_coll_sig_ctrl.sv
module tb_coll_sig_ctrl;
  localparam int DIV = 10;
  localparam int D   = 110;
  localparam int L   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic col = 1'b0, jab = 1'b0, eot = 1'b0, hben = 1'b1;
  logic cp, cn, act;
  int n_chk = 0, n_fail = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  coll_sig_ctrl #(.DIV(DIV), .HB_DELAY(D), .HB_LEN(L)) dut (
    .clk(clk), .rst(rst), .col_det_i(col), .jabber_i(jab), .tx_end_i(eot),
    .hb_enable_i(hben), .ci_p_o(cp), .ci_n_o(cn), .ci_active_o(act)
  );

  // Cycle model built from the requirements
  int m_ph, m_st, m_c;
  bit m_on, m_p, m_n, m_req, m_non;
  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_st <= 0; m_c <= 0; m_on <= 0; m_p <= 0; m_n <= 0;
    end else begin
      m_req = col | jab | (m_st == 2);
      m_non = (m_ph == 0) ? m_req : m_on;
      m_on <= m_non;
      m_p  <= m_non && (m_ph < DIV/2);
      m_n  <= m_non && !(m_ph < DIV/2);
      m_ph <= (m_ph == DIV-1) ? 0 : m_ph + 1;
      if (!hben) begin m_st <= 0; m_c <= 0; end
      else if (eot) begin m_st <= 1; m_c <= 0; end
      else if (m_st == 1) begin
        if (m_c == D-1) begin m_st <= 2; m_c <= 0; end else m_c <= m_c + 1;
      end else if (m_st == 2) begin
        if (m_c == L-1) begin m_st <= 0; m_c <= 0; end else m_c <= m_c + 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic string pick_tag(bit on, bit only_hb);
    if (!on) return "R4";
    if (only_hb) return "R5";
    return "R1";
  endfunction

  // sample at negedge, compare model, then drive next inputs
  task automatic step(input bit c, input bit j, input bit e, input bit h);
    @(negedge clk);
    check(act == m_on, pick_tag(m_on, !col && !jab), act, m_on);
    check(cp == m_p, pick_tag(m_on, !col && !jab), cp, m_p);
    check(cn == m_n, (m_on ? "R8" : "R4"), cn, m_n);
    col = c; jab = j; eot = e; hben = h;
  endtask

  // Run with fixed inputs until gate is seen active; returns cycles waited
  task automatic wait_active(input int maxc, output int k);
    k = 0;
    while (!act && k < maxc) begin step(col, jab, 1'b0, hben); k++; end
  endtask

  task automatic measure_active(input int maxc, output int len, output int highs);
    len = 0; highs = 0;
    while (act && len < maxc) begin
      if (cp) highs++;
      step(col, jab, 1'b0, hben); len++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int k, len, hi, first;
    bit sawon;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    @(negedge clk);
    check(cp == 0 && cn == 0 && act == 0, "R10", {cp, cn, act}, 0);

    // R2: collision
    step(1, 0, 0, 1);
    wait_active(DIV + 3, k);
    check(k <= DIV + 1, "R2", k, DIV + 1);
    check(cp == 1, "R9", cp, 1);
    hi = 0;
    for (int i = 0; i < 2*DIV; i++) begin
      if (cp) hi++;
      step(1, 0, 0, 1);
    end
    check(hi == DIV, "R1", hi, DIV);
    col = 0;
    measure_active(3*DIV, len, hi);
    check(act == 0 && len <= DIV, "R9", len, DIV);

    // R3: jabber, also check full-period closing
    repeat (7) step(0, 0, 0, 1);
    step(0, 1, 0, 1);
    wait_active(DIV + 3, k);
    check(k <= DIV + 1, "R3", k, DIV + 1);
    repeat (23) step(0, 1, 0, 1);
    step(0, 0, 0, 1);
    measure_active(3*DIV, len, hi);
    check((len + 24) % DIV == 0, "R9", (len + 24) % DIV, 0);
    repeat (5) step(0, 0, 0, 1);
    check(act == 0 && cp == 0 && cn == 0, "R4", act, 0);

    // R5: heartbeat timing and length
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    wait_active(D + 3*DIV, k);
    first = k + 1;
    check(first >= D + 2 && first <= D + 1 + DIV, "R5", first, D + 2);
    measure_active(L + 3*DIV, len, hi);
    check(len % DIV == 0 && len >= L && len <= L + DIV, "R5", len, L);
    check(hi * 2 == len, "R1", hi * 2, len);

    // R7: restart during pending heartbeat
    repeat (13) step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    repeat (59) step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    wait_active(D + 3*DIV, k);
    first = k + 1;
    check(first >= D + 2 && first <= D + 1 + DIV, "R7", first, D + 2);
    measure_active(L + 3*DIV, len, hi);
    // restart during running burst
    repeat (20) step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    step(0, 0, 0, 1);
    wait_active(D + 3*DIV, k);
    repeat (30) step(0, 0, 0, 1);
    step(0, 0, 1, 1);
    sawon = 0;
    for (int i = 0; i < D - 5; i++) begin step(0, 0, 0, 1); if (i > DIV + 2 && act) sawon = 1; end
    check(!sawon, "R7", sawon, 0);
    wait_active(3*DIV, k);
    check(act == 1, "R7", act, 1);
    measure_active(L + 3*DIV, len, hi);

    // R6: heartbeat disabled
    repeat (5) step(0, 0, 0, 0);
    step(0, 0, 1, 0);
    sawon = 0;
    for (int i = 0; i < D + L + 3*DIV; i++) begin step(0, 0, 0, 0); if (act) sawon = 1; end
    check(!sawon, "R6", sawon, 0);
    // cancel a pending heartbeat
    step(0, 0, 1, 1);
    repeat (40) step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    sawon = 0;
    for (int i = 0; i < D + L; i++) begin step(0, 0, 0, 1); if (act) sawon = 1; end
    check(!sawon, "R6", sawon, 0);
    step(1, 0, 0, 0);
    wait_active(DIV + 3, k);
    check(k <= DIV + 1, "R6", k, DIV + 1);
    step(0, 0, 0, 0);
    measure_active(3*DIV, len, hi);

    // Random traffic compared against the model every cycle
    for (int i = 0; i < 20000; i++) begin
      step(($urandom % 100) < 8 ? ~col : col,
           ($urandom % 100) < 3 ? ~jab : jab,
           ($urandom % 200) == 0,
           ($urandom % 500) == 0 ? ~hben : hben);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule